// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host sends 16-bit command words over a serial port made of four lines: an active-low chip select, a frame sync, a serial clock and a data line. Each word carries a channel address, a power bit, a speed bit and a 12-bit code. The receiver decodes the word and writes these values into a holding latch for the addressed channel. Each channel also has a live latch, and that latch drives the analog section.

A level-sensitive, active-low load input decides when the live latches follow the holding latches. Keeping it high lets the host stage new values for several channels; driving it low then updates them all together. An active-low power-down pin forces every channel's power-down flag on and leaves the stored bits untouched. All serial lines are sampled on the system clock `clk`, so the serial clock must run well below the system clock. Edges on the serial lines are found by comparing each input with its value one system clock earlier.

Top module: `qdac_cmd_rx`

## Requirements
- R1: After reset every channel code, fast flag and power bit reads 0; with `pd_n` high, `dac_pwrdn_o` reads 0.
- R2: A frame opens only on a falling `fs` while `cs_n` is low. Serial clocks with `cs_n` high, or with no such `fs` fall, change no output.
- R3: Bits are taken MSB first, one on each falling `sclk`. In the word, bits 15:14 are the channel (0=A, 1=B, 2=C, 3=D), bit 13 is power (1 = down), bit 12 is speed (1 = fast) and bits 11:0 are the code. Channel n drives `dac_code_o[12n+11:12n]`, `dac_fast_o[n]` and `dac_pwrdn_o[n]`.
- R4: A full 16-bit word is applied at the first rising `sclk` after the 16th falling edge, or at an earlier `fs` edge. Before that it has no effect. Falling edges after the 16th are ignored until the next frame.
- R5: If `fs` rises after 1 to 15 bits, the received bits are applied left-aligned, with the bits not received taken as 0. If `fs` rises with no bits received, nothing is applied.
- R6: If `cs_n` goes high before a word is applied, the word is discarded.
- R7: With `ldac_n` low, an applied word appears on its channel's outputs in the same system clock in which it is applied. The other channels do not change.
- R8: With `ldac_n` high, applied words are stored but no output changes. When `ldac_n` goes low, every channel loads its stored value.
- R9: While `pd_n` is low, every bit of `dac_pwrdn_o` reads 1, and writes still update the stored and live values. When `pd_n` goes high again, the outputs show the stored power bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync; a falling edge opens a frame |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load; live latches follow holding latches while low |
| pd_n | input | 1 | Active-low global power-down |
| dac_code_o | output | 48 | Four 12-bit live codes, channel A in the lowest bits |
| dac_fast_o | output | 4 | Per-channel fast-mode flag |
| dac_pwrdn_o | output | 4 | Per-channel power-down flag, forced on by `pd_n` low |

## Verification
The main decode path is exercised with several traffic patterns: full words, and serial clocks sent while chip select is high or without a frame-sync fall. It also sees a frame cut after eight bits, a frame cut with no bits, and a word aborted by chip select. Full words separate channel addressing and field positions. The cut frames separate left-aligned partial loading from discarding, and the sample taken between the 16th falling edge and the next rising edge separates correct apply timing from early loading. Staging with load held high, then releasing it, tells a level-gated live latch apart from one that loads on every write. Toggling power-down around a write shows that the override masks the stored power bits without changing them.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int QD_NUM_CH = 4;
    localparam int QD_CODE_W = 12;

    // address bits + power bit + speed bit + code bits
    function automatic int qd_word_w(input int num_ch, input int code_w);
        return $clog2(num_ch) + 2 + code_w;
    endfunction
endpackage

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fs,
    input  logic              sclk,
    input  logic              din,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic              active;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              sclk_p;
        logic              fs_p;
    } rx_t;

    rx_t q, d;

    logic sclk_fall, sclk_rise, fs_fall, fs_rise;
    logic [IDX_W-1:0] idx;

    assign sclk_fall = q.sclk_p & ~sclk;
    assign sclk_rise = ~q.sclk_p & sclk;
    assign fs_fall   = q.fs_p & ~fs;
    assign fs_rise   = ~q.fs_p & fs;
    assign idx       = IDX_W'(WORD_W - 1) - q.cnt[IDX_W-1:0];

    always_comb begin
        d        = q;
        commit_o = 1'b0;
        word_o   = q.shreg;
        d.sclk_p = sclk;
        d.fs_p   = fs;
        if (cs_n) begin
            d.active = 1'b0;
            d.armed  = 1'b0;
        end else begin
            // full word waiting for its closing edge
            if (q.armed && (sclk_rise || fs_rise || fs_fall)) begin
                commit_o = 1'b1;
                d.armed  = 1'b0;
            end
            // frame cut short by frame sync rising
            if (q.active && fs_rise && (q.cnt != '0)) begin
                commit_o = 1'b1;
            end
            if (fs_rise) begin
                d.active = 1'b0;
            end
            if (fs_fall) begin
                d.active = 1'b1;
                d.cnt    = '0;
                d.shreg  = '0;
            end else if (q.active && sclk_fall && !fs_rise) begin
                d.shreg[idx] = din;
                d.cnt        = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(WORD_W - 1)) begin
                    d.armed  = 1'b1;
                    d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/qdac_chan_latch.sv
module qdac_chan_latch #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              pwr_i,
    input  logic              spd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] code_o,
    output logic              fast_o,
    output logic              pwr_o
);
    typedef struct packed {
        logic              pwr;
        logic              spd;
        logic [CODE_W-1:0] code;
    } ent_t;

    typedef struct packed {
        ent_t held;
        ent_t live;
    } lat_t;

    lat_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.held = '{pwr: pwr_i, spd: spd_i, code: code_i};
        end
        if (!ldac_n) begin
            d.live = d.held;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign code_o = q.live.code;
    assign fast_o = q.live.spd;
    assign pwr_o  = q.live.pwr;
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx #(
    parameter int NUM_CH = qdac_pkg::QD_NUM_CH,
    parameter int CODE_W = qdac_pkg::QD_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     fs,
    input  logic                     sclk,
    input  logic                     din,
    input  logic                     ldac_n,
    input  logic                     pd_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        dac_fast_o,
    output logic [NUM_CH-1:0]        dac_pwrdn_o
);
    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int WORD_W = qdac_pkg::qd_word_w(NUM_CH, CODE_W);

    logic              rx_commit;
    logic [WORD_W-1:0] rx_word;
    logic [ADDR_W-1:0] w_addr;
    logic              w_pwr, w_spd;
    logic [CODE_W-1:0] w_code;
    logic [NUM_CH-1:0] live_pwr;

    qdac_frame_rx #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .fs       (fs),
        .sclk     (sclk),
        .din      (din),
        .commit_o (rx_commit),
        .word_o   (rx_word)
    );

    assign w_addr = rx_word[WORD_W-1 -: ADDR_W];
    assign w_pwr  = rx_word[CODE_W+1];
    assign w_spd  = rx_word[CODE_W];
    assign w_code = rx_word[CODE_W-1:0];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = rx_commit && (w_addr == ADDR_W'(ch));

        qdac_chan_latch #(.CODE_W(CODE_W)) u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (hit),
            .pwr_i  (w_pwr),
            .spd_i  (w_spd),
            .code_i (w_code),
            .ldac_n (ldac_n),
            .code_o (dac_code_o[ch*CODE_W +: CODE_W]),
            .fast_o (dac_fast_o[ch]),
            .pwr_o  (live_pwr[ch])
        );

        assign dac_pwrdn_o[ch] = live_pwr[ch] | ~pd_n;
    end
endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int WORD_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     ldac_n,
    input logic                     pd_n,
    input logic [NUM_CH*CODE_W-1:0] dac_code_o,
    input logic [NUM_CH-1:0]        dac_pwrdn_o,
    input logic                     rx_commit,
    input logic [WORD_W-1:0]        rx_word
);
    localparam int ADDR_W = $clog2(NUM_CH);

    logic [ADDR_W-1:0] sel;
    logic [CODE_W-1:0] new_code;
    assign sel      = rx_word[WORD_W-1 -: ADDR_W];
    assign new_code = rx_word[CODE_W-1:0];

    // R8: live codes hold while load is high
    p_hold_ldac_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_n |=> $stable(dac_code_o));

    // R9: global power-down forces every flag
    p_pd_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> (dac_pwrdn_o == {NUM_CH{1'b1}}));

    // R6: nothing is applied while chip select is high
    p_cs_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !rx_commit);

    // R7: applied code shows on the addressed channel at once
    p_apply_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_commit && !ldac_n) |=>
        (dac_code_o[$past(sel)*CODE_W +: CODE_W] == $past(new_code)));
endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ldac_n      (ldac_n),
    .pd_n        (pd_n),
    .dac_code_o  (dac_code_o),
    .dac_pwrdn_o (dac_pwrdn_o),
    .rx_commit   (rx_commit),
    .rx_word     (rx_word)
);

// File: tb/qdac_cmd_rx_bench.sv
module qdac_cmd_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, fs = 1'b1, sclk = 1'b0, din = 1'b0;
    logic        ldac_n = 1'b0, pd_n = 1'b1;
    logic [47:0] dac_code_o;
    logic [3:0]  dac_fast_o, dac_pwrdn_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    qdac_cmd_rx u_qdac_cmd_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .pd_n(pd_n), .dac_code_o(dac_code_o),
        .dac_fast_o(dac_fast_o), .dac_pwrdn_o(dac_pwrdn_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic        m_ps, m_pf;
    bit          m_open, m_full;
    logic        m_bits[$];
    logic [11:0] st_code[4], o_code[4];
    logic        st_p[4], st_s[4], o_p[4], o_s[4];
    logic [15:0] m_w;
    bit          m_apply;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ps = 1'b0; m_pf = 1'b0; m_open = 0; m_full = 0;
            m_bits.delete();
            for (int i = 0; i < 4; i++) begin
                st_code[i] = '0; o_code[i] = '0;
                st_p[i] = 0; st_s[i] = 0; o_p[i] = 0; o_s[i] = 0;
            end
        end else begin
            m_apply = 0;
            m_w = '0;
            foreach (m_bits[i]) m_w[15-i] = m_bits[i];
            if (cs_n) begin
                m_open = 0; m_full = 0; m_bits.delete();
            end else begin
                if (m_full && ((!m_ps && sclk) || (m_pf != fs))) begin
                    m_apply = 1; m_full = 0;
                end
                if (m_open && !m_pf && fs && m_bits.size() > 0) m_apply = 1;
                if (!m_pf && fs) m_open = 0;
                if (m_pf && !fs) begin
                    m_open = 1; m_bits.delete();
                end else if (m_open && m_ps && !sclk && !(!m_pf && fs)) begin
                    m_bits.push_back(din);
                    if (m_bits.size() == 16) begin
                        m_full = 1; m_open = 0;
                    end
                end
            end
            if (m_apply) begin
                st_code[m_w[15:14]] = m_w[11:0];
                st_p[m_w[15:14]]    = m_w[13];
                st_s[m_w[15:14]]    = m_w[12];
            end
            if (!ldac_n) begin
                for (int i = 0; i < 4; i++) begin
                    o_code[i] = st_code[i]; o_p[i] = st_p[i]; o_s[i] = st_s[i];
                end
            end
            m_ps = sclk; m_pf = fs;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [47:0] ec;
            logic [3:0]  ef, ep;
            for (int i = 0; i < 4; i++) begin
                ec[i*12 +: 12] = o_code[i];
                ef[i] = o_s[i];
                ep[i] = o_p[i] | ~pd_n;
            end
            chk("R3 R7 R8 R9 model code", {16'h0, dac_code_o}, {16'h0, ec});
            chk("R3 R7 R8 R9 model flags", {56'h0, dac_fast_o, dac_pwrdn_o}, {56'h0, ef, ep});
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(logic b);
        din = b; sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
    endtask

    task automatic send_bits(logic [15:0] w, int n);
        for (int i = 0; i < n; i++) sbit(w[15-i]);
    endtask

    task automatic open_frame();
        cs_n = 1'b0; tick(2);
        fs = 1'b0; tick(2);
    endtask

    task automatic send_word(logic [15:0] w);
        open_frame();
        send_bits(w, 16);
        sclk = 1'b1; tick(2);
        fs = 1'b1; tick(1);
        cs_n = 1'b1; tick(2);
    endtask

    function automatic logic [11:0] ch_code(int ch);
        return dac_code_o[ch*12 +: 12];
    endfunction

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 codes", {16'h0, dac_code_o}, 64'h0);
        chk("R1 fast", {60'h0, dac_fast_o}, 64'h0);
        chk("R1 pwrdn", {60'h0, dac_pwrdn_o}, 64'h0);

        // R3 R4 R7: channel B, fast, code ABC
        open_frame();
        send_bits(16'h5ABC, 16);
        chk("R4 before closing edge", {52'h0, ch_code(1)}, 64'h0);
        sclk = 1'b1; tick(2);
        chk("R3 channel B code", {52'h0, ch_code(1)}, 64'hABC);
        chk("R3 fast flags", {60'h0, dac_fast_o}, 64'h2);
        chk("R7 other channel A", {52'h0, ch_code(0)}, 64'h0);
        fs = 1'b1; tick(1); cs_n = 1'b1; tick(2);

        // R2: chip select high
        fs = 1'b0; tick(2);
        send_bits(16'h0123, 16);
        sclk = 1'b1; tick(2); fs = 1'b1; tick(2);
        chk("R2 cs high ignored", {52'h0, ch_code(0)}, 64'h0);

        // R2: clocks without frame sync fall
        cs_n = 1'b0; tick(2);
        send_bits(16'h0456, 16);
        sclk = 1'b1; tick(2);
        chk("R2 no fs fall ignored", {52'h0, ch_code(0)}, 64'h0);
        cs_n = 1'b1; tick(2);

        // R5: eight bits then fs rise -> 0xAC00
        open_frame();
        send_bits(16'hAC00, 8);
        fs = 1'b1; tick(2);
        chk("R5 partial code C", {52'h0, ch_code(2)}, 64'hC00);
        chk("R5 partial power C", {60'h0, dac_pwrdn_o}, 64'h4);
        chk("R5 partial fast", {60'h0, dac_fast_o}, 64'h2);
        cs_n = 1'b1; tick(2);

        // R5: zero bits then fs rise
        open_frame();
        fs = 1'b1; tick(2);
        chk("R5 empty frame", {16'h0, dac_code_o}, 64'h000C00ABC000);
        cs_n = 1'b1; tick(2);

        // R6: abort by chip select before closing edge
        open_frame();
        send_bits(16'hD555, 16);
        cs_n = 1'b1; tick(2);
        sclk = 1'b1; tick(2); fs = 1'b1; tick(2);
        chk("R6 aborted word", {52'h0, ch_code(3)}, 64'h0);

        // R4: extra falling edges after the 16th are ignored
        open_frame();
        send_bits(16'hE0F0, 16);
        sclk = 1'b1; tick(2);
        sbit(1'b1); sbit(1'b1);
        sclk = 1'b1; tick(2);
        chk("R4 extra bits ignored", {52'h0, ch_code(3)}, 64'h0F0);
        chk("R4 power flags", {60'h0, dac_pwrdn_o}, 64'hC);
        fs = 1'b1; tick(1); cs_n = 1'b1; tick(2);

        // R8: staging with load high, then release
        ldac_n = 1'b1;
        send_word(16'h1777);
        send_word(16'h9321);
        chk("R8 held codes", {16'h0, dac_code_o}, 64'h0F0C00ABC000);
        chk("R8 held power", {60'h0, dac_pwrdn_o}, 64'hC);
        ldac_n = 1'b0; tick(2);
        chk("R8 released codes", {16'h0, dac_code_o}, 64'h0F0321ABC777);
        chk("R8 released fast", {60'h0, dac_fast_o}, 64'h7);
        chk("R8 released power", {60'h0, dac_pwrdn_o}, 64'h8);

        // R9: global power-down
        pd_n = 1'b0; tick(1);
        chk("R9 forced power", {60'h0, dac_pwrdn_o}, 64'hF);
        send_word(16'h4001);
        chk("R9 write under pd code", {52'h0, ch_code(1)}, 64'h001);
        chk("R9 write under pd fast", {60'h0, dac_fast_o}, 64'h5);
        chk("R9 still forced", {60'h0, dac_pwrdn_o}, 64'hF);
        pd_n = 1'b1; tick(1);
        chk("R9 released power", {60'h0, dac_pwrdn_o}, 64'h8);

        tick(4);
        finish_up();
    end
endmodule